// File: doc/BRIEF.md
# Multi-Channel Transaction Interleaver

This block lets up to sixteen independent channel request sources share a single memory initiator port. Each channel presents request words (address, write flag, write data, last-word marker) on its own valid/ready pair. The block picks one channel at a time and passes that channel's words to the shared port. It tags every word with the channel's index in a transaction ID field. Because several channels can have transactions in flight together, their transactions are interleaved on the shared port.

Responses come back on the shared port in any order. Each carries the transaction ID of the request it answers. The block steers each response word, with its read data, error flag and last-word marker, to the channel that the ID names. A channel may hold only one outstanding transaction. Once its final request word has gone out, it stays out of arbitration until the last word of its response has been delivered. With that rule the ID alone is enough to route responses, and the number of transactions in flight never exceeds the number of channels.

Data is 32 bits wide. The address width and the ID width are parameters. The address may be up to 64 bits and the ID field is at least 4 bits.

Top module: `txn_interleaver`

## Requirements
- R1: After reset no channel is masked, the round-robin search starts at channel 0 and no burst is held. With no channel valid, `mem_req_valid` and every `ch_rsp_valid` bit are low, and with every `ch_rsp_ready` high `mem_rsp_ready` is high.
- R2: A forwarded word carries the granted channel's index on `mem_req_id`, with the upper ID bits zero. Its address, write flag, write data and last marker pass through unchanged. Only the granted channel sees `ch_req_ready` high, and only while `mem_req_ready` is high.
- R3: Grants rotate round-robin. After the last word of a transaction is accepted, the next search starts at the following channel index, and index NCH-1 wraps to 0.
- R4: Once the first word of a multi-word request is accepted, the grant stays with that channel until its last word is accepted. No other channel's word appears in between, even when other channels are valid.
- R5: A channel whose last request word has been accepted is not granted again until the response word with the last marker and that channel's ID has been accepted.
- R6: A response with an ID below NCH raises only `ch_rsp_valid[ID]`. Its read data, error flag and last marker appear unchanged on the channel response outputs.
- R7: Responses for different channels may return in any order relative to their requests, and each channel still receives exactly its own response words in order.
- R8: A request word that is offered and not accepted keeps its ID, address and data until it is accepted. `mem_rsp_ready` equals `ch_rsp_ready` of the channel that the response ID names.
- R9: The response error flag reaches the owning channel in the same cycle as the response word it comes with, including the word carrying the last marker.
- R10: A response whose ID is NCH or above is accepted (`mem_rsp_ready` high) and reaches no channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_req_valid | input | NCH | Per-channel request word valid |
| ch_req_write | input | NCH | Per-channel write (1) or read (0) |
| ch_req_last | input | NCH | Per-channel last word of the request |
| ch_req_addr | input | NCH*AW | Per-channel word address, channel i at bits [i*AW +: AW] |
| ch_req_wdata | input | NCH*32 | Per-channel write data, channel i at bits [i*32 +: 32] |
| ch_req_ready | output | NCH | Request word taken from channel i |
| mem_req_valid | output | 1 | Shared port request valid |
| mem_req_ready | input | 1 | Shared port request accepted |
| mem_req_write | output | 1 | Shared port write flag |
| mem_req_last | output | 1 | Shared port last word of request |
| mem_req_addr | output | AW | Shared port address |
| mem_req_wdata | output | 32 | Shared port write data |
| mem_req_id | output | IDW | Transaction ID (channel index) |
| mem_rsp_valid | input | 1 | Response word valid |
| mem_rsp_ready | output | 1 | Response word accepted |
| mem_rsp_id | input | IDW | Response transaction ID |
| mem_rsp_rdata | input | 32 | Response read data |
| mem_rsp_err | input | 1 | Response error flag |
| mem_rsp_last | input | 1 | Last word of response |
| ch_rsp_valid | output | NCH | Response word for channel i |
| ch_rsp_ready | input | NCH | Channel i accepts its response word |
| ch_rsp_rdata | output | 32 | Response data to the addressed channel |
| ch_rsp_err | output | 1 | Response error flag to the addressed channel |
| ch_rsp_last | output | 1 | Response last marker to the addressed channel |

## Verification
The embedded assertions watch, on every cycle, that a burst keeps its grant, that a stalled request holds its channel, that an outstanding channel is never granted or marked busy twice, that at most one channel sees a response, and that stray IDs are drained. The fairness order of the round-robin pointer, the out-of-order return of responses, and the data integrity of each word can only be shown by the bench's scenarios. There a scoreboard matches every word on the shared port and on each channel against the traffic the drivers issued, under both request-side and response-side backpressure.

// File: rtl/txn_pkg.sv
`timescale 1ns/1ps
package txn_pkg;
  localparam int unsigned TXN_DW      = 32;
  localparam int unsigned TXN_MAX_CH  = 16;
  localparam int unsigned TXN_MIN_IDW = 4;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/txn_rr_arb.sv
`timescale 1ns/1ps
module txn_rr_arb #(
  parameter int unsigned NCH = 4,
  parameter int unsigned CW  = txn_pkg::idx_w(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] elig,
  input  logic           cur_vld,
  input  logic           fire,
  input  logic           last,
  output logic [CW-1:0]  gnt_idx,
  output logic           gnt_act
);
  localparam int unsigned SW = CW + 1;

  logic [CW-1:0] ptr_q, ptr_d;
  logic          ptr_en;
  logic          locked_q, locked_d;
  logic [CW-1:0] lock_idx_q, lock_idx_d;
  logic [CW-1:0] pick;
  logic          found;
  logic [SW-1:0] cand;
  logic          done;

  // rotating search starting at the pointer
  always_comb begin
    pick  = ptr_q;
    found = 1'b0;
    cand  = '0;
    for (int k = 0; k < int'(NCH); k++) begin
      cand = {1'b0, ptr_q} + SW'(k);
      if (cand >= SW'(NCH)) cand = cand - SW'(NCH);
      if (!found && elig[cand[CW-1:0]]) begin
        pick  = cand[CW-1:0];
        found = 1'b1;
      end
    end
  end

  assign gnt_idx = locked_q ? lock_idx_q : pick;
  assign gnt_act = locked_q | found;
  assign done    = fire & last;

  always_comb begin
    locked_d   = done ? 1'b0 : (locked_q | cur_vld);
    lock_idx_d = locked_q ? lock_idx_q : gnt_idx;
    ptr_en     = done;
    ptr_d      = (gnt_idx == CW'(NCH - 1)) ? '0 : gnt_idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q      <= '0;
      locked_q   <= 1'b0;
      lock_idx_q <= '0;
    end else begin
      locked_q   <= locked_d;
      lock_idx_q <= lock_idx_d;
      if (ptr_en) ptr_q <= ptr_d;
    end
  end

  // R4: a burst word accepted without its last marker keeps the grant
  a_r4_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !last) |=> (gnt_idx == $past(gnt_idx)));

  // R8: an offered but refused word keeps its channel
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_vld && !fire) |=> (gnt_idx == $past(gnt_idx)));
endmodule

// File: rtl/txn_busy_trk.sv
`timescale 1ns/1ps
module txn_busy_trk #(
  parameter int unsigned NCH = 4,
  parameter int unsigned CW  = txn_pkg::idx_w(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           set_vld,
  input  logic [CW-1:0]  set_idx,
  input  logic           clr_vld,
  input  logic [CW-1:0]  clr_idx,
  output logic [NCH-1:0] busy
);
  logic [NCH-1:0] busy_q;

  for (genvar i = 0; i < int'(NCH); i++) begin : g_ch
    logic set_i, clr_i, en_i, d_i;
    always_comb begin
      set_i = set_vld && (set_idx == CW'(i));
      clr_i = clr_vld && (clr_idx == CW'(i));
      en_i  = set_i | clr_i;
      d_i   = set_i;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_q[i] <= 1'b0;
      else if (en_i) busy_q[i] <= d_i;
    end
  end

  assign busy = busy_q;

  // R5: a channel already in flight never gets a second transaction
  a_r5_set_idle: assert property (@(posedge clk) disable iff (!rst_n)
    set_vld |-> !busy_q[set_idx]);
endmodule

// File: rtl/txn_rsp_steer.sv
`timescale 1ns/1ps
module txn_rsp_steer #(
  parameter int unsigned NCH = 4,
  parameter int unsigned IDW = 4,
  parameter int unsigned CW  = txn_pkg::idx_w(NCH)
) (
  input  logic           mem_rsp_valid,
  input  logic [IDW-1:0] mem_rsp_id,
  input  logic [NCH-1:0] ch_rsp_ready,
  output logic [NCH-1:0] ch_rsp_valid,
  output logic           mem_rsp_ready,
  output logic           known
);
  logic [CW-1:0] dst;

  assign known = ({1'b0, mem_rsp_id} < (IDW + 1)'(NCH));
  assign dst   = mem_rsp_id[CW-1:0];

  for (genvar i = 0; i < int'(NCH); i++) begin : g_dst
    assign ch_rsp_valid[i] = mem_rsp_valid && known && (dst == CW'(i));
  end

  assign mem_rsp_ready = known ? ch_rsp_ready[dst] : 1'b1;
endmodule

// File: rtl/txn_interleaver.sv
`timescale 1ns/1ps
module txn_interleaver #(
  parameter int unsigned NCH = 4,
  parameter int unsigned AW  = 40,
  parameter int unsigned IDW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    ch_req_valid,
  input  logic [NCH-1:0]    ch_req_write,
  input  logic [NCH-1:0]    ch_req_last,
  input  logic [NCH*AW-1:0] ch_req_addr,
  input  logic [NCH*32-1:0] ch_req_wdata,
  output logic [NCH-1:0]    ch_req_ready,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic              mem_req_last,
  output logic [AW-1:0]     mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  output logic [IDW-1:0]    mem_req_id,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [IDW-1:0]    mem_rsp_id,
  input  logic [31:0]       mem_rsp_rdata,
  input  logic              mem_rsp_err,
  input  logic              mem_rsp_last,
  output logic [NCH-1:0]    ch_rsp_valid,
  input  logic [NCH-1:0]    ch_rsp_ready,
  output logic [31:0]       ch_rsp_rdata,
  output logic              ch_rsp_err,
  output logic              ch_rsp_last
);
  import txn_pkg::*;
  localparam int unsigned CW = idx_w(NCH);
  localparam int unsigned DW = TXN_DW;

  logic [NCH-1:0] busy, elig;
  logic [CW-1:0]  gnt_idx;
  logic           gnt_act, fire, rsp_known, rsp_done;

  assign elig = ch_req_valid & ~busy;

  txn_rr_arb #(.NCH(NCH), .CW(CW)) u_arb (
    .clk(clk), .rst_n(rst_n), .elig(elig), .cur_vld(mem_req_valid),
    .fire(fire), .last(mem_req_last), .gnt_idx(gnt_idx), .gnt_act(gnt_act)
  );

  // request side: mux the granted channel onto the shared port
  always_comb begin
    mem_req_valid = gnt_act & ch_req_valid[gnt_idx];
    mem_req_write = ch_req_write[gnt_idx];
    mem_req_last  = ch_req_last[gnt_idx];
    mem_req_addr  = ch_req_addr[int'(gnt_idx)*AW +: AW];
    mem_req_wdata = ch_req_wdata[int'(gnt_idx)*DW +: DW];
    mem_req_id    = IDW'(gnt_idx);
  end

  assign fire = mem_req_valid & mem_req_ready;

  for (genvar i = 0; i < int'(NCH); i++) begin : g_rdy
    assign ch_req_ready[i] = gnt_act & mem_req_ready & (gnt_idx == CW'(i));
  end

  // response side
  txn_rsp_steer #(.NCH(NCH), .IDW(IDW), .CW(CW)) u_steer (
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_id(mem_rsp_id),
    .ch_rsp_ready(ch_rsp_ready), .ch_rsp_valid(ch_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .known(rsp_known)
  );

  assign ch_rsp_rdata = mem_rsp_rdata;
  assign ch_rsp_err   = mem_rsp_err;
  assign ch_rsp_last  = mem_rsp_last;
  assign rsp_done     = mem_rsp_valid & mem_rsp_ready & mem_rsp_last & rsp_known;

  txn_busy_trk #(.NCH(NCH), .CW(CW)) u_busy (
    .clk(clk), .rst_n(rst_n),
    .set_vld(fire & mem_req_last), .set_idx(gnt_idx),
    .clr_vld(rsp_done), .clr_idx(mem_rsp_id[CW-1:0]),
    .busy(busy)
  );

  // R5: nothing is offered from a channel still waiting for its response
  a_r5_mask: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !busy[gnt_idx]);

  // R6: a response word reaches at most one channel
  a_r6_single_dest: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_rsp_valid));

  // R10: IDs outside the channel range are drained and go nowhere
  a_r10_stray_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_valid && ({1'b0, mem_rsp_id} >= (IDW + 1)'(NCH)))
      |-> (mem_rsp_ready && (ch_rsp_valid == '0)));
endmodule

// File: tb/txn_interleaver_test.sv
`timescale 1ns/1ps
module txn_interleaver_test;
  localparam int NCH = 4;
  localparam int AW  = 40;
  localparam int IDW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [NCH-1:0]    cv = '0, cw = '0, cl = '0;
  logic [NCH*AW-1:0] ca = '0;
  logic [NCH*32-1:0] cd = '0;
  logic [NCH-1:0]    ch_req_ready;
  logic              mem_req_valid, mem_req_write, mem_req_last;
  logic              mready = 1'b1;
  logic [AW-1:0]     mem_req_addr;
  logic [31:0]       mem_req_wdata;
  logic [IDW-1:0]    mem_req_id;
  logic              rv = 1'b0, rerr = 1'b0, rlast = 1'b0;
  logic [IDW-1:0]    rid = '0;
  logic [31:0]       rdata = '0;
  logic              mem_rsp_ready;
  logic [NCH-1:0]    ch_rsp_valid;
  logic [NCH-1:0]    crdy = '1;
  logic [31:0]       ch_rsp_rdata;
  logic              ch_rsp_err, ch_rsp_last;

  txn_interleaver #(.NCH(NCH), .AW(AW), .IDW(IDW)) uut (
    .clk(clk), .rst_n(rst_n),
    .ch_req_valid(cv), .ch_req_write(cw), .ch_req_last(cl),
    .ch_req_addr(ca), .ch_req_wdata(cd), .ch_req_ready(ch_req_ready),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mready),
    .mem_req_write(mem_req_write), .mem_req_last(mem_req_last),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata), .mem_req_id(mem_req_id),
    .mem_rsp_valid(rv), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_id(rid),
    .mem_rsp_rdata(rdata), .mem_rsp_err(rerr), .mem_rsp_last(rlast),
    .ch_rsp_valid(ch_rsp_valid), .ch_rsp_ready(crdy),
    .ch_rsp_rdata(ch_rsp_rdata), .ch_rsp_err(ch_rsp_err), .ch_rsp_last(ch_rsp_last)
  );

  int checks = 0;
  int errors = 0;

  // scoreboard storage
  logic [77:0] exp_req [$];   // ch[77:74] wr[73] last[72] addr[71:32] data[31:0]
  logic [37:0] exp_rsp [$];   // ch[37:34] err[33] last[32] data[31:0]
  logic [52:0] pending [$];   // id[52:49] wr[48] n[47:40] base[39:0]
  int          glog [$];
  int          rlog [$];
  logic [NCH-1:0] outst = '0;
  bit          resp_en = 1'b1;
  bit          rbusy = 1'b0;
  int          mr_mode = 0;
  bit          bp_en = 1'b0;
  bit          crdy_low = 1'b0;
  int          err_seen = 0;
  int          cyc = 0;

  task automatic chk(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] wd(input logic [AW-1:0] a, input int k);
    return a[31:0] ^ 32'h5A5A_0000 ^ 32'(k);
  endfunction

  function automatic logic [31:0] rd(input logic [AW-1:0] a, input int k);
    return ~a[31:0] + 32'(k * 3);
  endfunction

  // driver: one transaction of n words on channel ch
  task automatic send(input int ch, input bit wr, input logic [AW-1:0] base, input int n);
    for (int k = 0; k < n; k++) begin
      logic [AW-1:0] a;
      a = base + AW'(k * 4);
      @(negedge clk);
      cv[ch] = 1'b1;
      cw[ch] = wr;
      cl[ch] = (k == n - 1);
      ca[ch*AW +: AW] = a;
      cd[ch*32 +: 32] = wd(a, k);
      exp_req.push_back({4'(ch), wr, (k == n - 1), a, wd(a, k)});
      #3;
      while (!ch_req_ready[ch]) begin
        @(negedge clk);
        #3;
      end
    end
    @(negedge clk);
    cv[ch] = 1'b0;
  endtask

  // stimulus pacing
  initial forever begin
    @(negedge clk);
    cyc++;
    case (mr_mode)
      1:       mready = 1'b0;
      2:       mready = (cyc % 3) != 0;
      default: mready = 1'b1;
    endcase
    if (bp_en)         crdy = (cyc[0]) ? 4'b1010 : 4'b0111;
    else if (crdy_low) crdy = 4'b0000;
    else               crdy = 4'b1111;
  end

  // memory-side monitor (R2, R4, R5, R8)
  initial begin
    bit in_burst = 1'b0;
    int burst_id = 0;
    int nwords = 0;
    logic [AW-1:0] base = '0;
    bit prev_stall = 1'b0;
    logic [IDW-1:0] p_id = '0;
    logic [AW-1:0] p_addr = '0;
    logic [31:0] p_data = '0;
    forever begin
      @(negedge clk);
      #3;
      if (rst_n) begin
        if (prev_stall)
          chk(mem_req_valid && mem_req_id == p_id && mem_req_addr == p_addr && mem_req_wdata == p_data,
              "R8 stalled request held", {mem_req_valid, mem_req_id, mem_req_addr}, {1'b1, p_id, p_addr});
        prev_stall = mem_req_valid && !mready;
        p_id = mem_req_id; p_addr = mem_req_addr; p_data = mem_req_wdata;
        if (mem_req_valid && mready) begin
          int id, hit;
          id = int'(mem_req_id);
          chk(id < NCH, "R2 id in channel range", 80'(id), 80'(NCH - 1));
          hit = -1;
          for (int i = 0; i < exp_req.size(); i++)
            if (hit < 0 && int'(exp_req[i][77:74]) == id) hit = i;
          if (hit < 0) chk(1'b0, "R2 unexpected request word", 80'(mem_req_addr), 80'(0));
          else begin
            chk(exp_req[hit][73:0] == {mem_req_write, mem_req_last, mem_req_addr, mem_req_wdata},
                "R2 request fields", {mem_req_write, mem_req_last, mem_req_addr, mem_req_wdata}, exp_req[hit][73:0]);
            exp_req.delete(hit);
          end
          if (in_burst) chk(id == burst_id, "R4 burst contiguity", 80'(id), 80'(burst_id));
          else begin
            chk(!outst[id], "R5 outstanding channel granted", 80'(outst), 80'(0));
            glog.push_back(id);
            base = mem_req_addr;
            nwords = 0;
          end
          nwords++;
          if (mem_req_last) begin
            outst[id] = 1'b1;
            pending.push_back({4'(id), mem_req_write, 8'(nwords), base});
            in_burst = 1'b0;
          end else begin
            in_burst = 1'b1;
            burst_id = id;
          end
        end
      end
    end
  end

  // responder: serves the most recent pending transaction first
  initial forever begin
    @(negedge clk);
    if (resp_en && pending.size() > 0) begin
      logic [52:0] p;
      int nw;
      rbusy = 1'b1;
      p = pending.pop_back();
      nw = p[48] ? 1 : int'(p[47:40]);
      for (int k = 0; k < nw; k++) begin
        rv = 1'b1;
        rid = p[52:49];
        rdata = p[48] ? 32'h0 : rd(p[39:0], k);
        rerr = p[39] && (k == nw - 1);
        rlast = (k == nw - 1);
        exp_rsp.push_back({rid, rerr, rlast, rdata});
        #3;
        while (!mem_rsp_ready) begin
          @(negedge clk);
          #3;
        end
        @(negedge clk);
      end
      rv = 1'b0;
      rlast = 1'b0;
      rerr = 1'b0;
      rbusy = 1'b0;
    end
  end

  // channel-side monitor (R6, R7, R8, R9, R10)
  initial forever begin
    @(negedge clk);
    #3;
    if (rst_n) begin
      if (rv) begin
        int id;
        logic [NCH-1:0] expv;
        bit known;
        id = int'(rid);
        known = id < NCH;
        expv = known ? NCH'(1) << id : '0;
        chk(ch_rsp_valid == expv, "R6 response steering", 80'(ch_rsp_valid), 80'(expv));
        chk(mem_rsp_ready == (known ? crdy[id] : 1'b1), "R8 response ready follows owner",
            80'(mem_rsp_ready), 80'(known ? crdy[id] : 1'b1));
        if (known && mem_rsp_ready) begin
          int hit;
          hit = -1;
          for (int i = 0; i < exp_rsp.size(); i++)
            if (hit < 0 && int'(exp_rsp[i][37:34]) == id) hit = i;
          if (hit < 0) chk(1'b0, "R7 unexpected response", 80'(id), 80'(0));
          else begin
            chk(exp_rsp[hit][33:0] == {ch_rsp_err, ch_rsp_last, ch_rsp_rdata},
                "R6 R9 response fields", {ch_rsp_err, ch_rsp_last, ch_rsp_rdata}, exp_rsp[hit][33:0]);
            exp_rsp.delete(hit);
          end
          if (ch_rsp_err && ch_rsp_last) err_seen++;
          if (ch_rsp_last) begin
            outst[id] = 1'b0;
            rlog.push_back(id);
          end
        end
      end else begin
        chk(ch_rsp_valid == '0, "R6 idle response outputs", 80'(ch_rsp_valid), 80'(0));
      end
    end
  end

  task automatic drain();
    int t;
    t = 0;
    while ((exp_req.size() != 0 || pending.size() != 0 || exp_rsp.size() != 0 ||
            outst != '0 || rbusy) && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk(t < 3000, "drain completed", 80'(t), 80'(0));
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #3;
    // R1: idle outputs after reset
    chk(mem_req_valid == 1'b0, "R1 request idle", 80'(mem_req_valid), 80'(0));
    chk(ch_rsp_valid == '0, "R1 channel responses idle", 80'(ch_rsp_valid), 80'(0));
    chk(mem_rsp_ready == 1'b1, "R1 response ready", 80'(mem_rsp_ready), 80'(1));
    chk(ch_req_ready == '0, "R1 no channel ready", 80'(ch_req_ready), 80'(0));

    // R1 R3: all channels at once, pointer starts at 0
    glog.delete();
    mr_mode = 1;
    fork
      send(0, 1'b0, 40'h00_0000_1000, 1);
      send(1, 1'b0, 40'h00_0000_2000, 1);
      send(2, 1'b1, 40'h00_0000_3000, 1);
      send(3, 1'b0, 40'h00_0000_4000, 1);
      begin repeat (4) @(negedge clk); mr_mode = 0; end
    join
    drain();
    chk(glog.size() == 4 && glog[0] == 0 && glog[1] == 1 && glog[2] == 2 && glog[3] == 3,
        "R1 R3 first round order", 80'({glog[0], glog[1]}), 80'({32'd0, 32'd1}));

    // R3: after wrap to 0, channel 1 beats channel 3
    glog.delete();
    mr_mode = 1;
    fork
      send(3, 1'b0, 40'h00_0000_5000, 1);
      send(1, 1'b0, 40'h00_0000_6000, 1);
      begin repeat (3) @(negedge clk); mr_mode = 0; end
    join
    drain();
    chk(glog.size() == 2 && glog[0] == 1 && glog[1] == 3, "R3 second round order",
        80'({glog[0], glog[1]}), 80'({32'd1, 32'd3}));

    // R3: pointer left at 2 by channel 1 alone, so 3 goes before 0
    send(1, 1'b0, 40'h00_0000_7000, 1);
    drain();
    glog.delete();
    mr_mode = 1;
    fork
      send(0, 1'b0, 40'h00_0000_8000, 1);
      send(3, 1'b0, 40'h00_0000_9000, 1);
      begin repeat (3) @(negedge clk); mr_mode = 0; end
    join
    drain();
    chk(glog.size() == 2 && glog[0] == 3 && glog[1] == 0, "R3 wrap order",
        80'({glog[0], glog[1]}), 80'({32'd3, 32'd0}));

    // R4 R8: interleaved bursts under request and response backpressure
    mr_mode = 2;
    bp_en = 1'b1;
    fork
      send(0, 1'b1, 40'h00_0001_0000, 4);
      send(2, 1'b0, 40'h00_0002_0000, 3);
      send(1, 1'b0, 40'h00_0003_0000, 2);
      send(3, 1'b0, 40'h00_0004_0000, 4);
    join
    drain();
    bp_en = 1'b0;
    mr_mode = 0;

    // R5: second transaction of channel 1 waits for the first one's response
    resp_en = 1'b0;
    fork
      begin
        send(1, 1'b0, 40'h00_0005_0000, 1);
        send(1, 1'b0, 40'h00_0005_0100, 1);
      end
      begin
        repeat (8) @(negedge clk);
        #3;
        chk(cv[1] == 1'b1 && ch_req_ready[1] == 1'b0, "R5 busy channel held off",
            80'({cv[1], ch_req_ready[1]}), 80'(2'b10));
        chk(mem_req_valid == 1'b0, "R5 nothing offered while masked", 80'(mem_req_valid), 80'(0));
        resp_en = 1'b1;
      end
    join
    drain();

    // R7 R9: all four in flight, answered in reverse order, one with an error
    resp_en = 1'b0;
    err_seen = 0;
    glog.delete();
    rlog.delete();
    fork
      send(0, 1'b0, 40'h00_0006_0000, 2);
      send(1, 1'b1, 40'h00_0007_0000, 1);
      send(2, 1'b0, 40'h80_0008_0000, 2);
      send(3, 1'b0, 40'h00_0009_0000, 3);
    join
    repeat (4) @(negedge clk);
    resp_en = 1'b1;
    drain();
    chk(rlog.size() == 4 && glog.size() == 4 && rlog[0] == glog[3] && rlog[3] == glog[0],
        "R7 reverse return order", 80'({rlog[0], rlog[3]}), 80'({glog[3], glog[0]}));
    chk(err_seen == 1, "R9 error with last marker", 80'(err_seen), 80'(1));

    // R10: stray ID drained while every channel refuses
    resp_en = 1'b0;
    crdy_low = 1'b1;
    repeat (2) @(negedge clk);
    rv = 1'b1;
    rid = 4'd9;
    rlast = 1'b1;
    rdata = 32'hDEAD_0009;
    #3;
    chk(mem_rsp_ready == 1'b1, "R10 stray id accepted", 80'(mem_rsp_ready), 80'(1));
    chk(ch_rsp_valid == '0, "R10 stray id reaches no channel", 80'(ch_rsp_valid), 80'(0));
    @(negedge clk);
    rv = 1'b0;
    rlast = 1'b0;
    crdy_low = 1'b0;
    resp_en = 1'b1;
    repeat (3) @(negedge clk);

    chk(exp_req.size() == 0 && exp_rsp.size() == 0, "R7 scoreboard empty",
        80'(exp_req.size() + exp_rsp.size()), 80'(0));
    finish_run();
  end
endmodule